// File: doc/BRIEF.md
# Bus-Grouped Routing Switch Box

This block is the configurable switch point where one horizontal and one vertical routing channel cross. Each of the four sides (north, east, south, west) carries a channel of `W` single-bit tracks. The low-index tracks are coarse-grain: they are grouped in fours, and one configuration bit closes the same switch on all four tracks of a group, so a four-bit bus moves as one unit. The remaining tracks are fine-grain, and each has its own configuration bits. With the default parameters the channel is half coarse-grain and half fine-grain (one group of four plus four single tracks).

The topology is disjoint: track `i` on any side can reach only track `i` on the other sides. Every ordered side pair is a directional driver with its own enable. A logic cluster next to the switch point drives its outputs onto the south side through an output connection stage. That stage follows the same sharing rule: one bit per coarse group and one bit per fine track. A track that no enabled driver reaches reads zero. A configuration that enables two drivers onto the same track raises a conflict flag.

Configuration is loaded serially into a shadow chain. It becomes active only on a load strobe, so routing never changes while a new frame is being shifted in.

Top module: `sbx_bus_switch`

## Requirements
- R1: After synchronous reset, the shadow and active configuration are all zero, every track output is 0, and `cfg_conflict` is 0.
- R2: On each clock edge with `cfg_shift` high, `cfg_din` enters the shadow chain, and the shadow contents move one place toward the frame's first bit. A frame has `NB = 12*NU + NU` bits, where NU is the number of coarse groups plus the number of fine tracks. It is sent first bit first. It carries one 12-bit word per switch unit (coarse groups in order, then fine tracks in order), then one output-connection bit per unit in the same unit order. Within a unit word, the direction bit with the highest index is sent first.
- R3: The active configuration changes only on the clock edge where `cfg_load` is high. That edge copies the shadow chain into it. Shifting without a load leaves every output unchanged.
- R4: Sides are numbered N=0, E=1, S=2, W=3. Within a unit word, the enable for a driver from side `src` to side `dst` is bit `src*3 + (dst<src ? dst : dst-1)`. While that bit is set, `trk_out[dst][i]` follows `trk_in[src][i]` combinationally for every track `i` of the unit.
- R5: The bit for coarse group `g` switches tracks `4g` to `4g+3` together, and it affects no other track.
- R6: A fine-track unit bit controls only its own track. Fine unit `k` is track `4*N_CGRP + k`.
- R7: Track `i` on one side connects only to track `i` on other sides or to cluster output `i`, never to any other index.
- R8: The output-connection bit of unit `u` drives `clu_out` onto the south-side tracks of that unit. A coarse group's bit drives all four of its tracks. A fine track's bit drives only that track.
- R9: A track output with no enabled driver is 0, whatever the values on the inputs.
- R10: `cfg_conflict` is 1 exactly when the active configuration enables two or more drivers, including the cluster driver, onto the same track of the same side. Loading a configuration without such a clash clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_shift | input | 1 | Shift one configuration bit into the shadow chain |
| cfg_din | input | 1 | Serial configuration data |
| cfg_load | input | 1 | Copy the shadow chain into the active configuration |
| trk_in | input | 4 x W | Track values arriving on each side, indexed [side][track] |
| clu_out | input | W | Cluster outputs offered to the south-side tracks |
| trk_out | output | 4 x W | Track values driven out on each side, indexed [side][track] |
| cfg_conflict | output | 1 | Two or more drivers are enabled onto one track |

## Verification
The coarse group is driven with an asymmetric input byte so that its four tracks are seen to follow together, while the fine tracks next to it stay at zero. A single fine-track enable is driven with all-ones and then with the one bit cleared, which shows that it reaches one track and one index only. A frame that is shifted in without a load tells the shadow chain apart from the active configuration. Cluster tests cover both a shared group bit and a lone fine bit. Conflict tests put a clash on a coarse track and on a fine track with the cluster driver, then load a clean frame and check that the flag clears.

// File: rtl/sbx_pkg.sv
package sbx_pkg;

    localparam int GRP   = 4;   // tracks per coarse group
    localparam int NSIDE = 4;
    localparam int NDIR  = 12;  // ordered side pairs

    typedef enum logic [1:0] {SIDE_N = 2'd0, SIDE_E = 2'd1, SIDE_S = 2'd2, SIDE_W = 2'd3} side_e;

    localparam int CLU_SIDE = int'(SIDE_S);

    typedef struct packed {
        logic [NDIR-1:0] dir;
        logic            clu;
    } trk_cfg_t;

    // enable position inside a unit word for driver src -> dst
    function automatic int dir_bit(input int src, input int dst);
        if (src == dst) return 0;
        return src * 3 + ((dst < src) ? dst : dst - 1);
    endfunction

    // switch unit that owns a track: coarse groups first, then fine tracks
    function automatic int unit_of(input int trk, input int ncg);
        return (trk < GRP * ncg) ? trk / GRP : ncg + trk - GRP * ncg;
    endfunction

endpackage

// File: rtl/sbx_cfg_chain.sv
module sbx_cfg_chain #(
    parameter int NB = 65
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shift,
    input  logic          din,
    input  logic          load,
    output logic [NB-1:0] act
);
    logic [NB-1:0] shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            act    <= '0;
        end else begin
            if (shift) shadow <= {shadow[NB-2:0], din};
            if (load)  act    <= shadow;
        end
    end

    // R2
    shift_entry_chk: assert property (@(posedge clk) disable iff (rst)
        shift |=> shadow[0] == $past(din));

    // R3
    hold_active_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(act));

    // R3
    load_copy_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> act == $past(shadow));

endmodule

// File: rtl/sbx_track_xbar.sv
module sbx_track_xbar
    import sbx_pkg::*;
(
    input  logic [NSIDE-1:0] t_in,
    input  logic             clu_in,
    input  trk_cfg_t         cfg,
    output logic [NSIDE-1:0] t_out,
    output logic             conflict
);
    logic [2:0] cnt [NSIDE];

    always_comb begin
        conflict = 1'b0;
        for (int d = 0; d < NSIDE; d++) begin
            t_out[d] = 1'b0;
            cnt[d]   = 3'd0;
            for (int s = 0; s < NSIDE; s++) begin
                if (s != d && cfg.dir[dir_bit(s, d)]) begin
                    t_out[d] = t_out[d] | t_in[s];
                    cnt[d]   = cnt[d] + 3'd1;
                end
            end
            if (d == CLU_SIDE && cfg.clu) begin
                t_out[d] = t_out[d] | clu_in;
                cnt[d]   = cnt[d] + 3'd1;
            end
            if (cnt[d] > 3'd1) conflict = 1'b1;
        end
    end

endmodule

// File: rtl/sbx_bus_switch.sv
module sbx_bus_switch
    import sbx_pkg::*;
#(
    parameter int N_CGRP = 1,
    parameter int N_FINE = 4,
    parameter int W      = GRP * N_CGRP + N_FINE
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_shift,
    input  logic                     cfg_din,
    input  logic                     cfg_load,
    input  logic [NSIDE-1:0][W-1:0]  trk_in,
    input  logic [W-1:0]             clu_out,
    output logic [NSIDE-1:0][W-1:0]  trk_out,
    output logic                     cfg_conflict
);
    localparam int NU = N_CGRP + N_FINE;
    localparam int NO = NU;
    localparam int NB = NDIR * NU + NO;

    logic [NB-1:0] cfg_act;
    logic [W-1:0]  trk_conf;

    sbx_cfg_chain #(.NB(NB)) u_chain (
        .clk   (clk),
        .rst   (rst),
        .shift (cfg_shift),
        .din   (cfg_din),
        .load  (cfg_load),
        .act   (cfg_act)
    );

    for (genvar i = 0; i < W; i++) begin : g_trk
        localparam int U = unit_of(i, N_CGRP);
        trk_cfg_t         tc;
        logic [NSIDE-1:0] ti;
        logic [NSIDE-1:0] to;

        assign tc.dir = cfg_act[NO + (NU - 1 - U) * NDIR +: NDIR];
        assign tc.clu = cfg_act[NO - 1 - U];

        for (genvar s = 0; s < NSIDE; s++) begin : g_side
            assign ti[s]         = trk_in[s][i];
            assign trk_out[s][i] = to[s];

            // R7
            same_index_chk: assert property (@(posedge clk) disable iff (rst)
                trk_out[s][i] |-> ((|ti) || clu_out[i]));
        end

        sbx_track_xbar u_xbar (
            .t_in     (ti),
            .clu_in   (clu_out[i]),
            .cfg      (tc),
            .t_out    (to),
            .conflict (trk_conf[i])
        );
    end

    assign cfg_conflict = |trk_conf;

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_act == '0) |-> (trk_out == '0));

    // R10
    conflict_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_conflict |-> (cfg_act != '0));

endmodule

// File: tb/sim_sbx_bus_switch.sv
`timescale 1ns/1ps
module sim_sbx_bus_switch;
    localparam int W  = 8;
    localparam int NU = 5;
    localparam int NO = 5;
    localparam int NB = 12 * NU + NO;

    logic                clk = 1'b0;
    logic                rst;
    logic                cfg_shift, cfg_din, cfg_load;
    logic [3:0][W-1:0]   trk_in;
    logic [W-1:0]        clu_out;
    logic [3:0][W-1:0]   trk_out;
    logic                cfg_conflict;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sbx_bus_switch u0 (
        .clk(clk), .rst(rst), .cfg_shift(cfg_shift), .cfg_din(cfg_din),
        .cfg_load(cfg_load), .trk_in(trk_in), .clu_out(clu_out),
        .trk_out(trk_out), .cfg_conflict(cfg_conflict)
    );

    function automatic logic [NB-1:0] dirb(input int u, input int s, input int d);
        logic [NB-1:0] v = '0;
        v[NO + (NU - 1 - u) * 12 + s * 3 + ((d < s) ? d : d - 1)] = 1'b1;
        return v;
    endfunction

    function automatic logic [NB-1:0] outb(input int u);
        logic [NB-1:0] v = '0;
        v[NO - 1 - u] = 1'b1;
        return v;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_sides(input logic [W-1:0] n, input logic [W-1:0] e,
                             input logic [W-1:0] s, input logic [W-1:0] w, input string tag);
        chk({24'd0, trk_out[0]}, {24'd0, n}, {tag, " N"});
        chk({24'd0, trk_out[1]}, {24'd0, e}, {tag, " E"});
        chk({24'd0, trk_out[2]}, {24'd0, s}, {tag, " S"});
        chk({24'd0, trk_out[3]}, {24'd0, w}, {tag, " W"});
    endtask

    task automatic shift_frame(input logic [NB-1:0] v);
        for (int k = NB - 1; k >= 0; k--) begin
            @(negedge clk); cfg_shift = 1'b1; cfg_din = v[k];
        end
        @(negedge clk); cfg_shift = 1'b0; cfg_din = 1'b0;
    endtask

    task automatic strobe_load();
        cfg_load = 1'b1;
        @(negedge clk); cfg_load = 1'b0;
    endtask

    task automatic load_frame(input logic [NB-1:0] v);
        shift_frame(v);
        strobe_load();
    endtask

    task automatic t_reset();
        trk_in = {4{8'hFF}}; clu_out = 8'hFF;
        @(negedge clk);
        chk_sides(0, 0, 0, 0, "R1 R9 reset");
        chk({31'd0, cfg_conflict}, 0, "R1 conflict after reset");
    endtask

    task automatic t_coarse();
        load_frame(dirb(0, 3, 1));
        trk_in = '0; trk_in[3] = 8'hA5; clu_out = 8'hFF;
        #1 chk_sides(0, 8'h05, 0, 0, "R2 R4 R5 coarse W->E");
        trk_in = {4{8'hFF}};
        #1 chk_sides(0, 8'h0F, 0, 0, "R5 R7 coarse all ones");
    endtask

    task automatic t_fine();
        load_frame(dirb(2, 0, 2));
        trk_in = {4{8'hFF}}; clu_out = 8'hFF;
        #1 chk_sides(0, 0, 8'h20, 0, "R6 fine N->S track5");
        trk_in[0] = 8'hDF;
        #1 chk_sides(0, 0, 0, 0, "R6 R7 fine track5 low");
    endtask

    task automatic t_noload();
        trk_in = {4{8'hFF}};
        shift_frame(dirb(0, 3, 1));
        chk_sides(0, 0, 8'h20, 0, "R3 shift without load");
        strobe_load();
        chk_sides(0, 8'h0F, 0, 0, "R3 after load strobe");
    endtask

    task automatic t_cluster();
        load_frame(outb(0) | outb(4));
        trk_in = '0; clu_out = 8'hFF;
        #1 chk_sides(0, 0, 8'h8F, 0, "R8 cluster group and track7");
        clu_out = 8'h70;
        #1 chk_sides(0, 0, 0, 0, "R8 R9 cluster unselected bits");
    endtask

    task automatic t_conflict();
        load_frame(dirb(0, 0, 1) | dirb(0, 3, 1));
        #1 chk({31'd0, cfg_conflict}, 1, "R10 coarse clash");
        load_frame(dirb(1, 1, 2) | outb(1));
        #1 chk({31'd0, cfg_conflict}, 1, "R10 fine clash with cluster");
        load_frame(dirb(1, 1, 2) | outb(2));
        trk_in = '0; trk_in[1] = 8'hFF; clu_out = 8'hFF;
        #1 chk({31'd0, cfg_conflict}, 0, "R10 clean frame clears");
        chk_sides(0, 0, 8'h30, 0, "R6 R8 split fine drivers");
    endtask

    initial begin
        rst = 1'b1; cfg_shift = 1'b0; cfg_din = 1'b0; cfg_load = 1'b0;
        trk_in = '0; clu_out = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_coarse();
        t_fine();
        t_noload();
        t_cluster();
        t_conflict();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule